// File: doc/BRIEF.md
# SIMD Processing-Element Array with Broadcast

This block is a lock-step array of processing elements (PEs) that all obey one instruction stream issued by a control unit. Each PE owns an accumulator of twice the operand width, a routing register of operand width, and a private word-addressed memory. Instructions load, store, add a memory word into the accumulator, or multiply a memory word by the routing register. Further instructions copy the accumulator into the routing register and copy one chosen PE's routing register to every PE. The control unit can also force a constant into every accumulator, write a word into one chosen PE's memory, and load the per-PE mask and enable vectors that gate participation.

Instructions arrive on a valid/ready channel. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. The following cycle is its execute cycle: `done` is high, `in_ready` is low, and the PE state is written at the end of that cycle. An upstream source must hold `in_valid` and all instruction fields stable until the handshake. One instruction is therefore taken every two cycles at most.

A row of a matrix product is built by repeating one short sequence: load A[I,J] from its PE, copy it to routing, broadcast it from PE J, multiply by row J of B, add the partial row of C, and store it back.

Top module: `simd_pe_array`

## Requirements
- R1: `in_ready` is high whenever no instruction is executing. After a handshake, `done` is high and `in_ready` low for exactly the next cycle, and all PE state is stable in every cycle that follows a cycle without `done`.
- R2: LOAD (opcode 1) sets the accumulator of each active PE to its memory word at `in_addr`. ADD (opcode 3) adds that word to the accumulator, wrapping modulo 2^(2W).
- R3: RMUL (opcode 4) sets the accumulator of each active PE to the low W bits of its memory word at `in_addr` times its routing register, unsigned, modulo 2^(2W).
- R4: STORE (opcode 2) writes the accumulator of each active PE into its memory at `in_addr`. CUWR (opcode 10) writes `in_scalar` into the memory of PE `in_sel` only, whatever that PE's participation.
- R5: MOVR (opcode 5) copies the low W bits of the accumulator into the routing register of each active PE.
- R6: BCAST (opcode 6) copies the routing register of PE `in_sel`, taken before the update, into the routing register of every active PE.
- R7: CBCAST (opcode 7) sets the accumulator of every active PE to `in_scalar`.
- R8: A PE is active when both its enable bit and its mask bit are 1. An inactive PE keeps its accumulator, routing register and memory through LOAD, ADD, RMUL, STORE, MOVR, BCAST and CBCAST.
- R9: SETMASK (opcode 8) loads `in_vec` into the mask and SETEN (opcode 9) loads it into the enable vector, with bit k for PE k. `active` shows their AND.
- R10: Reset clears every accumulator, routing register and memory word, sets mask and enable to all ones, and leaves `in_ready` high and `done` low.
- R11: NOP (opcode 0) and opcodes 11 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Array can take an instruction |
| in_op | input | 4 | Opcode |
| in_addr | input | ADDR_W | Word address in each PE memory |
| in_sel | input | SEL_W | PE index for BCAST source and CUWR target |
| in_scalar | input | 2*OP_W | Constant for CBCAST and CUWR |
| in_vec | input | NUM_PE | Vector for SETMASK and SETEN |
| done | output | 1 | Execute-cycle strobe |
| active | output | NUM_PE | Per-PE participation (enable AND mask) |
| acc_flat | output | NUM_PE*2*OP_W | Accumulators, PE k at bits [k*2W +: 2W] |
| route_flat | output | NUM_PE*OP_W | Routing registers, PE k at bits [k*W +: W] |

## Verification
The main stimulus is a complete two-step row of a matrix product with distinct values in every PE. Broadcasts from two different source PEs show that the source index is honoured. Distinct B values per PE show that each PE reads its own memory. A masked-and-disabled phase uses separate mask and enable patterns so that only their AND selects the active PE, and a later load reveals whether inactive PEs stored anything. Wrap-around sums and a full-scale product test the width rules, and a CUWR word with a non-zero upper byte shows that the multiply uses only the low operand bits.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LOAD    = 4'd1,
    OP_STORE   = 4'd2,
    OP_ADD     = 4'd3,
    OP_RMUL    = 4'd4,
    OP_MOVR    = 4'd5,
    OP_BCAST   = 4'd6,
    OP_CBCAST  = 4'd7,
    OP_SETMASK = 4'd8,
    OP_SETEN   = 4'd9,
    OP_CUWR    = 4'd10
  } simd_op_e;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl #(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 2,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [ACC_W-1:0]  in_scalar,
  input  logic [NUM_PE-1:0] in_vec,
  output logic              busy_o,
  output logic [3:0]        x_op,
  output logic [ADDR_W-1:0] x_addr,
  output logic [SEL_W-1:0]  x_sel,
  output logic [ACC_W-1:0]  x_scalar,
  output logic [NUM_PE-1:0] active
);
  import simd_pkg::*;

  logic              busy_q;
  logic              accept;
  logic [NUM_PE-1:0] x_vec;
  logic [NUM_PE-1:0] mask_q;
  logic [NUM_PE-1:0] en_q;

  assign accept = in_valid & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      x_op     <= '0;
      x_addr   <= '0;
      x_sel    <= '0;
      x_scalar <= '0;
      x_vec    <= '0;
      mask_q   <= '1;
      en_q     <= '1;
    end else begin
      busy_q <= accept;
      if (accept) begin
        x_op     <= in_op;
        x_addr   <= in_addr;
        x_sel    <= in_sel;
        x_scalar <= in_scalar;
        x_vec    <= in_vec;
      end
      if (busy_q && x_op == OP_SETMASK) mask_q <= x_vec;
      if (busy_q && x_op == OP_SETEN)   en_q   <= x_vec;
    end
  end

  assign in_ready = ~busy_q;
  assign busy_o   = busy_q;
  assign active   = mask_q & en_q;
endmodule

// File: rtl/simd_route_net.sv
module simd_route_net #(
  parameter int NUM_PE = 4,
  parameter int OP_W   = 8,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_PE*OP_W-1:0] route_flat,
  input  logic [SEL_W-1:0]       sel,
  output logic [OP_W-1:0]        bcast_val,
  output logic [NUM_PE-1:0]      sel_hit
);
  always_comb begin
    bcast_val = '0;
    for (int k = 0; k < NUM_PE; k++) begin
      if (sel == SEL_W'(k)) bcast_val = route_flat[k*OP_W +: OP_W];
    end
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_hit
    assign sel_hit[g] = (sel == SEL_W'(g));
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe #(
  parameter int OP_W      = 8,
  parameter int MEM_DEPTH = 16,
  localparam int ACC_W    = 2 * OP_W,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACC_W-1:0]  scalar,
  input  logic              is_active,
  input  logic              cu_hit,
  input  logic [OP_W-1:0]   bcast_val,
  output logic [ACC_W-1:0]  acc,
  output logic [OP_W-1:0]   route
);
  import simd_pkg::*;

  logic [ACC_W-1:0] mem [MEM_DEPTH];
  logic [ACC_W-1:0] mem_rd;
  logic [ACC_W-1:0] sum_res;
  logic [ACC_W-1:0] mul_res;
  logic             go;

  assign mem_rd  = mem[addr];
  assign sum_res = acc + mem_rd;
  assign mul_res = ACC_W'(mem_rd[OP_W-1:0]) * ACC_W'(route);
  assign go      = exec_en & is_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      route <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (exec_en) begin
      case (op)
        OP_LOAD:   if (go) acc <= mem_rd;
        OP_STORE:  if (go) mem[addr] <= acc;
        OP_ADD:    if (go) acc <= sum_res;
        OP_RMUL:   if (go) acc <= mul_res;
        OP_MOVR:   if (go) route <= acc[OP_W-1:0];
        OP_BCAST:  if (go) route <= bcast_val;
        OP_CBCAST: if (go) acc <= scalar;
        OP_CUWR:   if (cu_hit) mem[addr] <= scalar;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array #(
  parameter int NUM_PE    = 4,
  parameter int OP_W      = 8,
  parameter int MEM_DEPTH = 16,
  localparam int ACC_W    = 2 * OP_W,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int SEL_W    = $clog2(NUM_PE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [3:0]              in_op,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [SEL_W-1:0]        in_sel,
  input  logic [ACC_W-1:0]        in_scalar,
  input  logic [NUM_PE-1:0]       in_vec,
  output logic                    done,
  output logic [NUM_PE-1:0]       active,
  output logic [NUM_PE*ACC_W-1:0] acc_flat,
  output logic [NUM_PE*OP_W-1:0]  route_flat
);
  logic              busy;
  logic [3:0]        x_op;
  logic [ADDR_W-1:0] x_addr;
  logic [SEL_W-1:0]  x_sel;
  logic [ACC_W-1:0]  x_scalar;
  logic [OP_W-1:0]   bcast_val;
  logic [NUM_PE-1:0] sel_hit;

  simd_ctrl #(
    .NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .ACC_W(ACC_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_sel(in_sel), .in_scalar(in_scalar),
    .in_vec(in_vec), .busy_o(busy), .x_op(x_op), .x_addr(x_addr),
    .x_sel(x_sel), .x_scalar(x_scalar), .active(active)
  );

  simd_route_net #(
    .NUM_PE(NUM_PE), .OP_W(OP_W), .SEL_W(SEL_W)
  ) i_net (
    .route_flat(route_flat), .sel(x_sel), .bcast_val(bcast_val), .sel_hit(sel_hit)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    simd_pe #(
      .OP_W(OP_W), .MEM_DEPTH(MEM_DEPTH)
    ) i_pe (
      .clk(clk), .rst_n(rst_n), .exec_en(busy), .op(x_op), .addr(x_addr),
      .scalar(x_scalar), .is_active(active[g]), .cu_hit(sel_hit[g]),
      .bcast_val(bcast_val),
      .acc(acc_flat[g*ACC_W +: ACC_W]),
      .route(route_flat[g*OP_W +: OP_W])
    );
  end

  assign done = busy;
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk #(
  parameter int NUM_PE    = 4,
  parameter int OP_W      = 8,
  parameter int MEM_DEPTH = 16,
  localparam int ACC_W    = 2 * OP_W,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int SEL_W    = $clog2(NUM_PE)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [3:0]              in_op,
  input logic [ADDR_W-1:0]       in_addr,
  input logic [SEL_W-1:0]        in_sel,
  input logic [ACC_W-1:0]        in_scalar,
  input logic [NUM_PE-1:0]       in_vec,
  input logic                    done,
  input logic [NUM_PE-1:0]       active,
  input logic [NUM_PE*ACC_W-1:0] acc_flat,
  input logic [NUM_PE*OP_W-1:0]  route_flat
);
  import simd_pkg::*;

  logic [OP_W-1:0] src_rt;
  logic            take;

  always_comb begin
    src_rt = '0;
    for (int k = 0; k < NUM_PE; k++) begin
      if (in_sel == SEL_W'(k)) src_rt = route_flat[k*OP_W +: OP_W];
    end
  end

  assign take = in_valid && in_ready;

  AST_TAKE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> done); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(acc_flat) && $stable(route_flat))); // R1

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe_chk
    AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !active[g]) |=> ($stable(acc_flat[g*ACC_W +: ACC_W]) &&
                                $stable(route_flat[g*OP_W +: OP_W]))); // R8
    AST_CBCAST_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_op == OP_CBCAST && active[g]) |-> ##2
        (acc_flat[g*ACC_W +: ACC_W] == $past(in_scalar, 2))); // R7
    AST_BCAST_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_op == OP_BCAST && active[g]) |-> ##2
        (route_flat[g*OP_W +: OP_W] == $past(src_rt, 2))); // R6
  end
endmodule

bind simd_pe_array simd_pe_array_chk #(
  .NUM_PE(NUM_PE), .OP_W(OP_W), .MEM_DEPTH(MEM_DEPTH)
) i_chk (.*);

// File: tb/test_simd_pe_array.sv
`timescale 1ns/1ps
module test_simd_pe_array;
  import simd_pkg::*;

  localparam int NPE = 4;
  localparam int W   = 8;
  localparam int DEP = 16;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  addr;
    logic [1:0]  sel;
    logic [15:0] sc;
    logic [3:0]  vec;
    logic [63:0] acc;
    logic [31:0] rt;
    logic [3:0]  act;
  } step_t;

  localparam int NSTEP = 43;
  localparam step_t TBL [NSTEP] = '{
    '{OP_CUWR,   4'd0, 2'd0, 16'd2,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd0, 2'd1, 16'd3,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd1, 2'd0, 16'd1,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd1, 2'd1, 16'd2,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd1, 2'd2, 16'd3,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd1, 2'd3, 16'd4,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd2, 2'd0, 16'd5,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd2, 2'd1, 16'd6,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd2, 2'd2, 16'd7,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CUWR,   4'd2, 2'd3, 16'd8,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CBCAST, 4'd0, 2'd0, 16'd9,     4'h0, {16'd9,16'd9,16'd9,16'd9},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_CBCAST, 4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_STORE,  4'd3, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_LOAD,   4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd0,8'd0,8'd0,8'd0},         4'hF},
    '{OP_MOVR,   4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd0,8'd0,8'd3,8'd2},         4'hF},
    '{OP_BCAST,  4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd2,8'd2,8'd2,8'd2},         4'hF},
    '{OP_RMUL,   4'd1, 2'd0, 16'd0,     4'h0, {16'd8,16'd6,16'd4,16'd2},           {8'd2,8'd2,8'd2,8'd2},         4'hF},
    '{OP_ADD,    4'd3, 2'd0, 16'd0,     4'h0, {16'd8,16'd6,16'd4,16'd2},           {8'd2,8'd2,8'd2,8'd2},         4'hF},
    '{OP_STORE,  4'd3, 2'd0, 16'd0,     4'h0, {16'd8,16'd6,16'd4,16'd2},           {8'd2,8'd2,8'd2,8'd2},         4'hF},
    '{OP_LOAD,   4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd2,8'd2,8'd2,8'd2},         4'hF},
    '{OP_MOVR,   4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd0,8'd0,8'd3,8'd2},         4'hF},
    '{OP_BCAST,  4'd0, 2'd1, 16'd0,     4'h0, {16'd0,16'd0,16'd3,16'd2},           {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_RMUL,   4'd2, 2'd0, 16'd0,     4'h0, {16'd24,16'd21,16'd18,16'd15},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_ADD,    4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd27,16'd22,16'd17},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_STORE,  4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd27,16'd22,16'd17},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_CBCAST, 4'd0, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'd0,16'd0},           {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_LOAD,   4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd27,16'd22,16'd17},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_SETMASK,4'd0, 2'd0, 16'd0,     4'h5, {16'd32,16'd27,16'd22,16'd17},       {8'd3,8'd3,8'd3,8'd3},         4'h5},
    '{OP_CBCAST, 4'd0, 2'd0, 16'd100,   4'h0, {16'd32,16'd100,16'd22,16'd100},     {8'd3,8'd3,8'd3,8'd3},         4'h5},
    '{OP_SETEN,  4'd0, 2'd0, 16'd0,     4'h3, {16'd32,16'd100,16'd22,16'd100},     {8'd3,8'd3,8'd3,8'd3},         4'h1},
    '{OP_ADD,    4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd100,16'd22,16'd117},     {8'd3,8'd3,8'd3,8'd3},         4'h1},
    '{OP_STORE,  4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd100,16'd22,16'd117},     {8'd3,8'd3,8'd3,8'd3},         4'h1},
    '{OP_SETEN,  4'd0, 2'd0, 16'd0,     4'hF, {16'd32,16'd100,16'd22,16'd117},     {8'd3,8'd3,8'd3,8'd3},         4'h5},
    '{OP_SETMASK,4'd0, 2'd0, 16'd0,     4'hF, {16'd32,16'd100,16'd22,16'd117},     {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_LOAD,   4'd3, 2'd0, 16'd0,     4'h0, {16'd32,16'd27,16'd22,16'd117},      {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_CBCAST, 4'd0, 2'd0, 16'hFFF0,  4'h0, {16'hFFF0,16'hFFF0,16'hFFF0,16'hFFF0}, {8'd3,8'd3,8'd3,8'd3},       4'hF},
    '{OP_ADD,    4'd3, 2'd0, 16'd0,     4'h0, {16'd16,16'd11,16'd6,16'd101},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_CUWR,   4'd4, 2'd0, 16'h00FF,  4'h0, {16'd16,16'd11,16'd6,16'd101},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_CUWR,   4'd4, 2'd1, 16'h0102,  4'h0, {16'd16,16'd11,16'd6,16'd101},       {8'd3,8'd3,8'd3,8'd3},         4'hF},
    '{OP_CBCAST, 4'd0, 2'd0, 16'h01FF,  4'h0, {16'h01FF,16'h01FF,16'h01FF,16'h01FF}, {8'd3,8'd3,8'd3,8'd3},       4'hF},
    '{OP_MOVR,   4'd0, 2'd0, 16'd0,     4'h0, {16'h01FF,16'h01FF,16'h01FF,16'h01FF}, {8'hFF,8'hFF,8'hFF,8'hFF},   4'hF},
    '{OP_RMUL,   4'd4, 2'd0, 16'd0,     4'h0, {16'd0,16'd0,16'h01FE,16'hFE01},     {8'hFF,8'hFF,8'hFF,8'hFF},     4'hF},
    '{4'd15,     4'd3, 2'd2, 16'h1234,  4'h0, {16'd0,16'd0,16'h01FE,16'hFE01},     {8'hFF,8'hFF,8'hFF,8'hFF},     4'hF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [3:0]  in_addr = '0;
  logic [1:0]  in_sel = '0;
  logic [15:0] in_scalar = '0;
  logic [3:0]  in_vec = '0;
  logic        done;
  logic [3:0]  active;
  logic [63:0] acc_flat;
  logic [31:0] route_flat;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simd_pe_array #(.NUM_PE(NPE), .OP_W(W), .MEM_DEPTH(DEP)) i_simd_pe_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_sel(in_sel), .in_scalar(in_scalar),
    .in_vec(in_vec), .done(done), .active(active), .acc_flat(acc_flat),
    .route_flat(route_flat)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      OP_LOAD, OP_ADD:       return "R2";
      OP_RMUL:               return "R3";
      OP_STORE, OP_CUWR:     return "R4";
      OP_MOVR:               return "R5";
      OP_BCAST:              return "R6";
      OP_CBCAST:             return "R7";
      OP_SETMASK, OP_SETEN:  return "R9";
      default:               return "R11";
    endcase
  endfunction

  // Offer one instruction while idle; checks the R1 timing of the handshake.
  task automatic issue(input logic [3:0] op, input logic [3:0] addr,
                       input logic [1:0] sel, input logic [15:0] sc,
                       input logic [3:0] vec);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = addr; in_sel = sel;
    in_scalar = sc; in_vec = vec;
    chk(in_ready === 1'b1, "R1 ready while idle", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(done === 1'b1 && in_ready === 1'b0, "R1 execute cycle",
        64'({done, in_ready}), 64'b10);
    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R1 back to idle",
        64'({done, in_ready}), 64'b01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready === 1'b1 && done === 1'b0, "R10 handshake at reset",
        64'({in_ready, done}), 64'b10);
    chk(acc_flat === 64'd0, "R10 accumulators at reset", acc_flat, 64'd0);
    chk(route_flat === 32'd0, "R10 routing at reset", 64'(route_flat), 64'd0);
    chk(active === 4'hF, "R10 participation at reset", 64'(active), 64'hF);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: matrix row, masking, wrap and width cases
    for (int i = 0; i < NSTEP; i++) begin
      issue(TBL[i].op, TBL[i].addr, TBL[i].sel, TBL[i].sc, TBL[i].vec);
      chk(acc_flat === TBL[i].acc, {tag_of(TBL[i].op), " accumulators"},
          acc_flat, TBL[i].acc);
      chk(route_flat === TBL[i].rt, {tag_of(TBL[i].op), " routing"},
          64'(route_flat), 64'(TBL[i].rt));
      chk(active === TBL[i].act, "R8 participation vector",
          64'(active), 64'(TBL[i].act));
    end

    // R1: a valid held during the execute cycle is taken only after it
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_CBCAST; in_scalar = 16'd7; in_addr = '0;
    @(negedge clk);
    chk(in_ready === 1'b0 && done === 1'b1, "R1 busy while first executes",
        64'({in_ready, done}), 64'b01);
    in_op = OP_ADD; in_addr = 4'd3; in_scalar = '0;
    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R1 second not taken while busy",
        64'({done, in_ready}), 64'b01);
    chk(acc_flat === {16'd7,16'd7,16'd7,16'd7}, "R7 first of back-to-back",
        acc_flat, {16'd7,16'd7,16'd7,16'd7});
    @(negedge clk);
    in_valid = 1'b0;
    chk(done === 1'b1, "R1 second executes", 64'(done), 64'd1);
    @(negedge clk);
    chk(acc_flat === {16'd39,16'd34,16'd29,16'd124}, "R2 add after back-to-back",
        acc_flat, {16'd39,16'd34,16'd29,16'd124});

    // R10: reset in mid-run clears state and memory
    issue(OP_SETMASK, 4'd0, 2'd0, 16'd0, 4'h2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_flat === 64'd0 && route_flat === 32'd0, "R10 state after reset",
        acc_flat, 64'd0);
    chk(active === 4'hF, "R10 mask and enable after reset", 64'(active), 64'hF);
    chk(in_ready === 1'b1 && done === 1'b0, "R10 handshake after reset",
        64'({in_ready, done}), 64'b10);
    rst_n = 1'b1;
    issue(OP_LOAD, 4'd3, 2'd0, 16'd0, 4'h0);
    chk(acc_flat === 64'd0, "R10 memory cleared", acc_flat, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule